// File: doc/BRIEF.md
# Quadrature Step Generator with End-of-Move Marker

This block drives one channel of an incremental-encoder style output. It produces two square-wave phases A and B in quadrature, a marker pulse M that flags the end of a move, and an auxiliary level. A move is loaded in a single-cycle strobe. The strobe carries a 24-bit count of quadrature edges, a 24-bit width value that sets the time between edges, a direction, a 2-bit marker-width code and the auxiliary level that applies once the move finishes.

The time between edges comes from a width timer. The timer reloads with the width value at every emitted edge and is clocked by a prescaler with two settings: every system clock, or every `COARSE_DIV` clocks. A down counter holds the edges still to be emitted. Its live value is brought out, together with a zero flag that a command queue can use to feed the next move. The marker rises at the last edge of a move and may stay high into the following move, up to the width chosen by its code. A synchronous clear input forces both phases low at any time.

Top module: `quad_step_gen`

## Requirements
- R1: The phase pair is written (A,B). Counting up (`ld_up`=1) steps 00→10→11→01→00. Counting down (`ld_up`=0) steps 00→01→11→10→00.
- R2: Each emitted edge changes exactly one of A and B, so four edges return the pair to its starting value. Between edges both phases hold.
- R3: With `coarse_sel`=0 and width value N, the first edge comes (N+1) clocks after the load cycle, and each later edge comes (N+1) clocks after the one before.
- R4: With `coarse_sel`=1 (held from the load on), every interval above is multiplied by `COARSE_DIV` (33 by default) clocks.
- R5: `remaining` equals the loaded count from the cycle after the load and drops by one at each edge. `at_zero` is high exactly when `remaining` is 0, and no edge is emitted while it is high.
- R6: Loading a count of 0 emits no edge, leaves `at_zero` high, and applies the loaded auxiliary level on the next cycle.
- R7: Marker code 0 never raises `marker` at the end of its move.
- R8: Codes 1, 2 and 3 give marker spans of 1, 2 and 4 counts. `marker` rises at the final edge of the move and falls at the edge that ends the span, counting the edges of the moves that follow. With no further edges it stays high.
- R9: The auxiliary level latched with a move reaches `aux_out` at that move's final edge and not before.
- R10: `quad_clear` high forces A=B=0 on the next cycle, whatever the move state.
- R11: After reset A, B, `marker` and `aux_out` are 0, `remaining` is 0 and `at_zero` is 1.
- R12: A load while a move is running discards the rest of that move and restarts the edge timing from the new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quad_clear | input | 1 | Force both phases low |
| coarse_sel | input | 1 | 1 selects the slow prescaler tick |
| load | input | 1 | Single-cycle move load strobe |
| ld_count | input | CNT_W | Number of quadrature edges in the move |
| ld_width | input | WID_W | Width value N; edge period is N+1 ticks |
| ld_up | input | 1 | Direction, 1 = up |
| ld_mark_code | input | 2 | Marker span code (0/1/2/4 counts) |
| ld_aux | input | 1 | Auxiliary level applied at move end |
| phase_a | output | 1 | Quadrature phase A |
| phase_b | output | 1 | Quadrature phase B |
| marker | output | 1 | End-of-move marker |
| aux_out | output | 1 | Auxiliary level |
| remaining | output | CNT_W | Edges still to emit |
| at_zero | output | 1 | Move complete / idle |

## Verification
A width timer off by one shows up in the first move as an edge one tick early or late. An off-by-one in the down counter shows on `remaining` in the cycle after the first edge, and as an extra or missing edge at the end of the move. A marker span counter that is wrong shows only during the following move, at the edge where `marker` should fall, so marker spans are checked across chained moves. A wrong phase transition breaks the one-phase-per-edge rule on the very next clock.

// File: rtl/qsg_pkg.sv
package qsg_pkg;

  // Phase pair packed as {A,B}
  typedef logic [1:0] ab_t;

  // Next quadrature state in the requested direction
  function automatic ab_t next_ab(ab_t cur, logic up);
    ab_t nxt;
    if (up) begin
      unique case (cur)
        2'b00:   nxt = 2'b10;
        2'b10:   nxt = 2'b11;
        2'b11:   nxt = 2'b01;
        default: nxt = 2'b00;
      endcase
    end else begin
      unique case (cur)
        2'b00:   nxt = 2'b01;
        2'b01:   nxt = 2'b11;
        2'b11:   nxt = 2'b10;
        default: nxt = 2'b00;
      endcase
    end
    return nxt;
  endfunction

  // Marker span in counts for a code
  function automatic logic [2:0] mark_span(logic [1:0] code);
    logic [2:0] s;
    unique case (code)
      2'd0:    s = 3'd0;
      2'd1:    s = 3'd1;
      2'd2:    s = 3'd2;
      default: s = 3'd4;
    endcase
    return s;
  endfunction

  // Counts the marker stays high after the final edge's own count
  function automatic logic [1:0] mark_extra(logic [1:0] code);
    logic [2:0] s;
    s = mark_span(code);
    return (s == 3'd0) ? 2'd0 : 2'(s - 3'd1);
  endfunction

endpackage

// File: rtl/qsg_prescaler.sv
module qsg_prescaler #(
  parameter int COARSE_DIV = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic coarse,
  output logic tick
);
  generate
    if (COARSE_DIV > 1) begin : g_div
      localparam int DIV_W = $clog2(COARSE_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(COARSE_DIV - 1);
      logic [DIV_W-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (restart)    cnt <= '0;
        else if (!coarse)    cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end

      assign tick = coarse ? (cnt == LAST) : 1'b1;
    end else begin : g_nodiv
      logic unused_in;
      assign unused_in = &{1'b0, clk, rst_n, restart, coarse};
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/qsg_width_timer.sv
module qsg_width_timer #(
  parameter int WID_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WID_W-1:0] ld_width,
  input  logic             tick,
  input  logic             active,
  output logic             step
);
  logic [WID_W-1:0] reload_q;
  logic [WID_W-1:0] timer_q;

  // An edge is due when the timer has run out on a tick of a live move
  assign step = active && tick && (timer_q == '0) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      timer_q  <= '0;
    end else if (load) begin
      reload_q <= ld_width;
      timer_q  <= ld_width;
    end else if (active && tick) begin
      if (timer_q == '0) timer_q <= reload_q;
      else               timer_q <= timer_q - 1'b1;
    end
  end
endmodule

// File: rtl/qsg_move_counter.sv
module qsg_move_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_count,
  input  logic             ld_up,
  input  logic             step,
  output logic [CNT_W-1:0] remaining,
  output logic             active,
  output logic             up_dir,
  output logic             final_step,
  output logic             zero_load
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q;

  assign remaining  = rem_q;
  assign active     = (rem_q != '0);
  assign final_step = step && (rem_q == ONE);
  assign zero_load  = load && (ld_count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      up_dir <= 1'b1;
    end else if (load) begin
      rem_q  <= ld_count;
      up_dir <= ld_up;
    end else if (step) begin
      rem_q  <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/qsg_phase_marker.sv
module qsg_phase_marker
  import qsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       quad_clear,
  input  logic       load,
  input  logic [1:0] ld_mark_code,
  input  logic       ld_aux,
  input  logic       step,
  input  logic       final_step,
  input  logic       zero_load,
  input  logic       up_dir,
  output logic       phase_a,
  output logic       phase_b,
  output logic       marker,
  output logic       aux_out,
  output logic [1:0] code_q
);
  ab_t        ab_q;
  logic       aux_pend_q;
  logic [1:0] left_q;

  assign phase_a = ab_q[1];
  assign phase_b = ab_q[0];

  // Phase state
  always_ff @(posedge clk) begin
    if (!rst_n)          ab_q <= 2'b00;
    else if (quad_clear) ab_q <= 2'b00;
    else if (step)       ab_q <= next_ab(ab_q, up_dir);
  end

  // Per-move attributes latched at load
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q     <= 2'd0;
      aux_pend_q <= 1'b0;
    end else if (load) begin
      code_q     <= ld_mark_code;
      aux_pend_q <= ld_aux;
    end
  end

  // Auxiliary level: applied at completion of the move
  always_ff @(posedge clk) begin
    if (!rst_n)          aux_out <= 1'b0;
    else if (zero_load)  aux_out <= ld_aux;
    else if (final_step) aux_out <= aux_pend_q;
  end

  // Marker span: rises at a final edge, counted down on later edges
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      marker <= 1'b0;
      left_q <= 2'd0;
    end else if (final_step) begin
      marker <= (code_q != 2'd0);
      left_q <= mark_extra(code_q);
    end else if (step && marker) begin
      if (left_q == 2'd0) marker <= 1'b0;
      else                left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/quad_step_gen.sv
module quad_step_gen #(
  parameter int CNT_W      = 24,
  parameter int WID_W      = 24,
  parameter int COARSE_DIV = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quad_clear,
  input  logic             coarse_sel,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_count,
  input  logic [WID_W-1:0] ld_width,
  input  logic             ld_up,
  input  logic [1:0]       ld_mark_code,
  input  logic             ld_aux,
  output logic             phase_a,
  output logic             phase_b,
  output logic             marker,
  output logic             aux_out,
  output logic [CNT_W-1:0] remaining,
  output logic             at_zero
);
  // Named internal events
  logic       tick;
  logic       step;
  logic       active;
  logic       up_dir;
  logic       final_step;
  logic       zero_load;
  logic [1:0] held_code;

  assign at_zero = !active;

  qsg_prescaler #(.COARSE_DIV(COARSE_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(load), .coarse(coarse_sel), .tick(tick)
  );

  qsg_width_timer #(.WID_W(WID_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_width(ld_width),
    .tick(tick), .active(active), .step(step)
  );

  qsg_move_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_count(ld_count), .ld_up(ld_up),
    .step(step), .remaining(remaining), .active(active), .up_dir(up_dir),
    .final_step(final_step), .zero_load(zero_load)
  );

  qsg_phase_marker u_phase (
    .clk(clk), .rst_n(rst_n), .quad_clear(quad_clear), .load(load),
    .ld_mark_code(ld_mark_code), .ld_aux(ld_aux), .step(step),
    .final_step(final_step), .zero_load(zero_load), .up_dir(up_dir),
    .phase_a(phase_a), .phase_b(phase_b), .marker(marker),
    .aux_out(aux_out), .code_q(held_code)
  );
endmodule

// File: rtl/quad_step_gen_checker.sv
module quad_step_gen_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             quad_clear,
  input logic             load,
  input logic [CNT_W-1:0] ld_count,
  input logic             step,
  input logic             final_step,
  input logic [1:0]       held_code,
  input logic             phase_a,
  input logic             phase_b,
  input logic             marker,
  input logic [CNT_W-1:0] remaining,
  input logic             at_zero
);
  assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !quad_clear) |=>
      $countones({phase_a, phase_b} ^ $past({phase_a, phase_b})) == 1);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !quad_clear) |=> $stable({phase_a, phase_b}));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    quad_clear |=> (!phase_a && !phase_b));

  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (remaining == $past(remaining) - CNT_W'(1)));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !load) |=> at_zero);

  assert_zero_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ld_count == '0) |=> at_zero);

  assert_no_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (final_step && held_code == 2'd0) |=> !marker);

  assert_marker_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (final_step && held_code != 2'd0) |=> marker);
endmodule

bind quad_step_gen quad_step_gen_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .quad_clear(quad_clear), .load(load),
  .ld_count(ld_count), .step(step), .final_step(final_step),
  .held_code(held_code), .phase_a(phase_a), .phase_b(phase_b),
  .marker(marker), .remaining(remaining), .at_zero(at_zero)
);

// File: tb/quad_step_gen_test.sv
`timescale 1ns/1ps
module quad_step_gen_test;
  localparam int CNT_W = 24;
  localparam int WID_W = 24;
  localparam int DIV   = 33;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             quad_clear = 1'b0;
  logic             coarse_sel = 1'b0;
  logic             load = 1'b0;
  logic [CNT_W-1:0] ld_count = '0;
  logic [WID_W-1:0] ld_width = '0;
  logic             ld_up = 1'b1;
  logic [1:0]       ld_mark_code = 2'd0;
  logic             ld_aux = 1'b0;
  logic             phase_a, phase_b, marker, aux_out, at_zero;
  logic [CNT_W-1:0] remaining;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [1:0] exp_ab   = 2'b00;
  int         exp_mrem = 0;
  logic       exp_aux  = 1'b0;

  always #2.5 clk = ~clk;

  quad_step_gen #(.CNT_W(CNT_W), .WID_W(WID_W), .COARSE_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .quad_clear(quad_clear), .coarse_sel(coarse_sel),
    .load(load), .ld_count(ld_count), .ld_width(ld_width), .ld_up(ld_up),
    .ld_mark_code(ld_mark_code), .ld_aux(ld_aux), .phase_a(phase_a),
    .phase_b(phase_b), .marker(marker), .aux_out(aux_out),
    .remaining(remaining), .at_zero(at_zero)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // R1 ring written as a lookup in up order
  function automatic logic [1:0] ring_step(logic [1:0] ab, bit up);
    logic [1:0] ring [4] = '{2'b00, 2'b10, 2'b11, 2'b01};
    int idx = 0;
    for (int k = 0; k < 4; k++) if (ring[k] == ab) idx = k;
    return ring[(idx + (up ? 1 : 3)) % 4];
  endfunction

  function automatic int span_of(int code);
    return (code == 3) ? 4 : code;
  endfunction

  function automatic int period_of(int wid, bit coarse);
    return (wid + 1) * (coarse ? DIV : 1);
  endfunction

  // Model update at each emitted edge
  task automatic model_edge(bit up, bit last, int code, bit aux);
    exp_ab = ring_step(exp_ab, up);
    if (last) begin
      exp_mrem = span_of(code);
      exp_aux  = aux;
    end else if (exp_mrem > 0) begin
      exp_mrem--;
    end
  endtask

  task automatic do_load(int cnt, int wid, bit up, int code, bit aux, bit coarse);
    coarse_sel   = coarse;
    ld_count     = CNT_W'(cnt);
    ld_width     = WID_W'(wid);
    ld_up        = up;
    ld_mark_code = 2'(code);
    ld_aux       = aux;
    load         = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Called at a negedge; returns at the negedge after the final edge
  task automatic run_move(int cnt, int wid, bit up, int code, bit aux, bit coarse);
    int p;
    p = period_of(wid, coarse);
    do_load(cnt, wid, up, code, aux, coarse);
    check(remaining == CNT_W'(cnt), "R5 loaded", remaining, cnt);
    for (int i = 1; i <= cnt; i++) begin
      if (p > 1) begin
        repeat (p - 1) @(negedge clk);
        check({phase_a, phase_b} == exp_ab, (coarse ? "R4 hold" : "R3 hold"),
              {phase_a, phase_b}, exp_ab);
        check(aux_out == exp_aux, "R9 aux early", aux_out, exp_aux);
      end
      @(negedge clk);
      model_edge(up, i == cnt, code, aux);
      check({phase_a, phase_b} == exp_ab, (up ? "R1 up" : "R1 down"),
            {phase_a, phase_b}, exp_ab);
      check(remaining == CNT_W'(cnt - i), "R5 count", remaining, cnt - i);
      check(marker == (exp_mrem > 0), (code == 0 && i == cnt) ? "R7 marker" : "R8 marker",
            marker, exp_mrem > 0);
    end
    check(at_zero == 1'b1, "R5 at_zero", at_zero, 1);
    check(aux_out == exp_aux, "R9 aux applied", aux_out, exp_aux);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    logic [1:0] start_ab;
    seed_dummy = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check({phase_a, phase_b, marker, aux_out} == 4'b0, "R11 outputs", {phase_a, phase_b, marker, aux_out}, 0);
    check(remaining == '0 && at_zero, "R11 counter", remaining, 0);

    // R1/R2/R3 up, four edges return to start
    start_ab = exp_ab;
    run_move(4, 0, 1'b1, 0, 1'b0, 1'b0);
    check({phase_a, phase_b} == start_ab, "R2 four edges", {phase_a, phase_b}, start_ab);
    run_move(3, 2, 1'b0, 0, 1'b1, 1'b0);
    run_move(5, 1, 1'b1, 0, 1'b0, 1'b0);

    // R4 coarse prescaler
    run_move(2, 1, 1'b0, 0, 1'b0, 1'b1);

    // R8 marker spans extending into chained moves
    run_move(2, 0, 1'b1, 3, 1'b1, 1'b0);
    run_move(6, 1, 1'b1, 2, 1'b0, 1'b0);
    run_move(3, 0, 1'b0, 1, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    check(marker == 1'b1, "R8 marker held idle", marker, 1);
    run_move(2, 0, 1'b0, 0, 1'b0, 1'b0);
    check(marker == 1'b0, "R7 code zero", marker, 0);

    // R6 zero count
    start_ab = exp_ab;
    do_load(0, 0, 1'b1, 3, 1'b1, 1'b0);
    exp_aux = 1'b1;
    check(at_zero == 1'b1, "R6 at_zero", at_zero, 1);
    check(aux_out == 1'b1, "R6 aux", aux_out, 1);
    repeat (6) @(negedge clk);
    check({phase_a, phase_b} == start_ab, "R6 no edge", {phase_a, phase_b}, start_ab);
    check(marker == 1'b0 && remaining == '0, "R6 marker", marker, 0);

    // R12 load during a move
    do_load(10, 2, 1'b1, 0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    model_edge(1'b1, 1'b0, 0, 1'b0);
    check({phase_a, phase_b} == exp_ab, "R12 first edge", {phase_a, phase_b}, exp_ab);
    run_move(2, 3, 1'b0, 1, 1'b1, 1'b0);
    check(remaining == '0, "R12 replaced", remaining, 0);

    // R10 clear
    if (exp_ab == 2'b00) run_move(1, 0, 1'b1, 0, exp_aux, 1'b0);
    quad_clear = 1'b1;
    @(negedge clk);
    quad_clear = 1'b0;
    exp_ab = 2'b00;
    check({phase_a, phase_b} == 2'b00, "R10 clear", {phase_a, phase_b}, 0);

    // Random moves
    for (int n = 0; n < 40; n++) begin
      int  c, w, code;
      bit  up, ax, co;
      c    = 1 + int'($urandom % 8);
      co   = ($urandom % 4) == 0;
      w    = int'($urandom % (co ? 2 : 5));
      code = int'($urandom % 4);
      up   = $urandom % 2;
      ax   = $urandom % 2;
      run_move(c, w, up, code, ax, co);
      if (($urandom % 6) == 0) begin
        quad_clear = 1'b1;
        @(negedge clk);
        quad_clear = 1'b0;
        exp_ab = 2'b00;
        check({phase_a, phase_b} == 2'b00, "R10 clear rand", {phase_a, phase_b}, 0);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule